// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous client and an external asynchronous static RAM. The client asks for one access at a time with a request flag, a write/read select, an address and write data. The block answers with a single-cycle acknowledge, and for reads it returns the captured word alongside that acknowledge. On the memory side it drives an address bus and two active-low strobes: write enable and output enable. It also owns its half of a shared bidirectional data bus.

Every memory timing figure is a parameter counted in clock cycles. Writes run in three phases: address and data are set up, write enable is pulsed low, and the values are then held. Reads insert one turnaround cycle with the bus released, then hold output enable low for the programmed access latency, and capture the bus on the last cycle of that window. The strobes come straight from flip-flops, so they cannot glitch.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, write enable and output enable are both high (inactive) and acknowledge is low.
- R2: Each write drives write enable low for exactly T_PULSE consecutive cycles, once.
- R3: Address and write data are on the memory pins for at least T_SETUP cycles before write enable falls.
- R4: Address and write data stay on the pins for exactly T_HOLD cycles after write enable rises. Acknowledge then follows, T_SETUP+T_PULSE+T_HOLD+1 clock edges after the request is raised.
- R5: Write enable and output enable are never low in the same cycle.
- R6: The data driver is released at least one cycle before output enable falls, and it stays released while output enable is low.
- R7: Each read holds output enable low for exactly T_RDLAT cycles. The read returns the bus value on the last of those cycles, and acknowledge comes T_RDLAT+2 clock edges after the request is raised.
- R8: Acknowledge is high for a single cycle. For reads, the returned word is valid in that cycle.
- R9: The request fields (select, address, data) are sampled only when a request is accepted from idle. Changing them later in the transaction has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_req | input | 1 | Client request, held until acknowledge |
| cl_wr | input | 1 | 1 = write, 0 = read |
| cl_addr | input | AW | Client address |
| cl_wdata | input | DW | Client write data |
| cl_ack | output | 1 | One-cycle completion pulse |
| cl_rdata | output | DW | Read data, valid with acknowledge |
| sr_addr | output | AW | Memory address bus |
| sr_dq | inout | DW | Shared memory data bus |
| sr_we_n | output | 1 | Memory write enable, active low |
| sr_oe_n | output | 1 | Memory output enable, active low |

## Verification
Each test writes every address with an arithmetic pattern, then reads each one back. This separates correct addressing from aliasing. Further patterns cover all-zero data, all-one data and walking-one data, which expose stuck or swapped bus bits. The bench memory model returns a garbage word until output enable has been low for the full latency, so a capture taken one cycle early is visible. Strobe widths, setup and hold windows and acknowledge latency are measured at the pins and compared with sums of the timing parameters. A request whose fields change in mid-flight is then read back, which shows whether the late values leaked into the transaction.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_TURN,
    ST_RDWAIT,
    ST_DONE
  } sramc_state_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sramc_rst_sync.sv
module sramc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_PULSE = 3,
  parameter int unsigned T_HOLD  = 1,
  parameter int unsigned T_RDLAT = 3,
  parameter int unsigned CW      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          accept,
  output logic          capture,
  output logic          we_n,
  output logic          oe_n,
  output logic          drv,
  output logic          ack
);

  sramc_state_e state_q, state_d;
  logic we_n_q, oe_n_q, drv_q, ack_q;
  logic [CW:0] pulse_cnt_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (req_wr) begin
            state_d  = ST_SETUP;
            tmr_load = 1'b1;
            tmr_val  = CW'(T_SETUP - 1);
          end else begin
            state_d = ST_TURN;
          end
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = CW'(T_PULSE - 1);
        end
      end
      ST_PULSE: begin
        if (tmr_zero) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = CW'(T_HOLD - 1);
        end
      end
      ST_HOLD:   if (tmr_zero) state_d = ST_DONE;
      ST_TURN: begin
        state_d  = ST_RDWAIT;
        tmr_load = 1'b1;
        tmr_val  = CW'(T_RDLAT - 1);
      end
      ST_RDWAIT: if (tmr_zero) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign accept  = (state_q == ST_IDLE) && req;
  assign capture = (state_q == ST_RDWAIT) && tmr_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      drv_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      we_n_q  <= (state_d != ST_PULSE);
      oe_n_q  <= (state_d != ST_RDWAIT);
      drv_q   <= (state_d == ST_SETUP) || (state_d == ST_PULSE) || (state_d == ST_HOLD);
      ack_q   <= (state_d == ST_DONE);
    end
  end

  assign we_n = we_n_q;
  assign oe_n = oe_n_q;
  assign drv  = drv_q;
  assign ack  = ack_q;

  // Low-time counter of the write strobe, used by the pulse-width checks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pulse_cnt_q <= '0;
    else if (we_n_q) pulse_cnt_q <= '0;
    else             pulse_cnt_q <= pulse_cnt_q + 1'b1;
  end

  a_r2_pulse_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n_q) |-> (pulse_cnt_q == (CW+1)'(T_PULSE)));
  a_r2_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> (pulse_cnt_q < (CW+1)'(T_PULSE)));
  a_r5_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_q && !oe_n_q));
  a_r6_released_before_oe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n_q) |-> !$past(drv_q));
  a_r6_no_drive_during_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> !drv_q);
  a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);

endmodule

// File: rtl/sramc_dpath.sv
module sramc_dpath #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= bus_in;
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned DW      = 16,
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_PULSE = 3,
  parameter int unsigned T_HOLD  = 1,
  parameter int unsigned T_RDLAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cl_req,
  input  logic          cl_wr,
  input  logic [AW-1:0] cl_addr,
  input  logic [DW-1:0] cl_wdata,
  output logic          cl_ack,
  output logic [DW-1:0] cl_rdata,
  output logic [AW-1:0] sr_addr,
  inout  wire  [DW-1:0] sr_dq,
  output logic          sr_we_n,
  output logic          sr_oe_n
);

  localparam int unsigned MAXT = max4(T_SETUP, T_PULSE, T_HOLD, T_RDLAT);
  localparam int unsigned CW   = (MAXT < 2) ? 1 : $clog2(MAXT);

  logic          rst_i_n;
  logic          tmr_load, tmr_zero, accept, capture, drv;
  logic [CW-1:0] tmr_val;
  logic [DW-1:0] wdata_q;

  sramc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sramc_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sramc_seq #(
    .T_SETUP (T_SETUP),
    .T_PULSE (T_PULSE),
    .T_HOLD  (T_HOLD),
    .T_RDLAT (T_RDLAT),
    .CW      (CW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .req      (cl_req),
    .req_wr   (cl_wr),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .accept   (accept),
    .capture  (capture),
    .we_n     (sr_we_n),
    .oe_n     (sr_oe_n),
    .drv      (drv),
    .ack      (cl_ack)
  );

  sramc_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .accept   (accept),
    .capture  (capture),
    .in_addr  (cl_addr),
    .in_wdata (cl_wdata),
    .bus_in   (sr_dq),
    .addr_q   (sr_addr),
    .wdata_q  (wdata_q),
    .rdata_q  (cl_rdata)
  );

  assign sr_dq = drv ? wdata_q : 'z;

  a_r3_addr_stable_at_strobe: assert property (@(posedge clk) disable iff (!rst_i_n)
    $fell(sr_we_n) |-> ($stable(sr_addr) && $past(drv)));
  a_r4_addr_stable_at_release: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(sr_we_n) |-> ($stable(sr_addr) && drv));
  a_r7_capture_under_oe: assert property (@(posedge clk) disable iff (!rst_i_n)
    capture |-> !sr_oe_n);

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int TS = 2;
  localparam int TP = 3;
  localparam int TH = 1;
  localparam int TR = 3;
  localparam int CLK_PERIOD = 10;
  localparam logic [DW-1:0] GARBAGE = 16'hBAD0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cl_req = 1'b0, cl_wr = 1'b0;
  logic [AW-1:0] cl_addr = '0;
  logic [DW-1:0] cl_wdata = '0;
  logic          cl_ack;
  logic [DW-1:0] cl_rdata;
  logic [AW-1:0] sr_addr;
  wire  [DW-1:0] sr_dq;
  logic          sr_we_n, sr_oe_n;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_async_ctrl #(
    .AW(AW), .DW(DW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_RDLAT(TR)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cl_req(cl_req), .cl_wr(cl_wr), .cl_addr(cl_addr),
    .cl_wdata(cl_wdata), .cl_ack(cl_ack), .cl_rdata(cl_rdata), .sr_addr(sr_addr),
    .sr_dq(sr_dq), .sr_we_n(sr_we_n), .sr_oe_n(sr_oe_n)
  );

  // Behavioural memory: garbage until output enable has been low TR cycles.
  logic [DW-1:0] mem [1 << AW];
  int oe_cnt = 0;
  always @(posedge clk) begin
    if (!sr_we_n) mem[sr_addr] <= sr_dq;
    if (sr_oe_n) oe_cnt <= 0;
    else         oe_cnt <= oe_cnt + 1;
  end
  assign sr_dq = (!sr_oe_n && sr_we_n) ? ((oe_cnt >= TR - 1) ? mem[sr_addr] : GARBAGE) : 'z;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Pin monitor, sampled on the falling edge.
  int lowrun = 0, oerun = 0, stab = 0, holdcnt = 0;
  bit in_hold = 0, pwe = 1, poe = 1;
  logic [AW-1:0] pa = '0, ha = '0;
  logic [DW-1:0] pd = '0, hd = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(!sr_we_n && !sr_oe_n), "R5 both enables low", {sr_we_n, sr_oe_n}, 32'h3);
      if (sr_addr == pa && sr_dq == pd) stab++; else stab = 1;
      if (pwe && !sr_we_n) chk(stab >= TS + 1, "R3 setup cycles", stab, TS + 1);
      if (!sr_we_n) begin
        lowrun++;
        ha = sr_addr; hd = sr_dq;
      end else if (lowrun > 0) begin
        chk(lowrun == TP, "R2 write pulse width", lowrun, TP);
        lowrun = 0; in_hold = 1; holdcnt = 0;
      end
      if (in_hold) begin
        if (cl_ack) begin
          chk(holdcnt == TH, "R4 hold cycles", holdcnt, TH);
          in_hold = 0;
        end else begin
          holdcnt++;
          chk(sr_addr == ha && sr_dq == hd, "R4 held values", {sr_addr, sr_dq}, {ha, hd});
        end
      end
      if (!sr_oe_n) oerun++;
      else if (oerun > 0) begin
        chk(oerun == TR, "R7 output enable width", oerun, TR);
        oerun = 0;
      end
      pa = sr_addr; pd = sr_dq; pwe = sr_we_n; poe = sr_oe_n;
    end
  end

  task automatic wait_ack(input int exp_n, input string tag);
    int n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!cl_ack && n < 100);
    chk(n == exp_n, tag, n, exp_n);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cl_req = 1; cl_wr = 1; cl_addr = a; cl_wdata = d;
    wait_ack(TS + TP + TH + 1, "R4 write ack latency");
    cl_req = 0;
    @(negedge clk);
    chk(!cl_ack, "R8 ack one cycle (write)", cl_ack, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    @(negedge clk);
    cl_req = 1; cl_wr = 0; cl_addr = a;
    wait_ack(TR + 2, "R7 read ack latency");
    chk(cl_rdata == exp, "R7 R8 read data with ack", cl_rdata, exp);
    cl_req = 0;
    @(negedge clk);
    chk(!cl_ack, "R8 ack one cycle (read)", cl_ack, 0);
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 40503) ^ 16'h5A5A;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(sr_we_n && sr_oe_n && !cl_ack, "R1 reset state", {sr_we_n, sr_oe_n, cl_ack}, 3'b110);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(sr_we_n && sr_oe_n && !cl_ack, "R1 idle after reset", {sr_we_n, sr_oe_n, cl_ack}, 3'b110);

    for (int a = 0; a < (1 << AW); a++) do_write(AW'(a), pat(a));
    for (int a = 0; a < (1 << AW); a++) do_read(AW'(a), pat(a));

    do_write(8'h10, 16'h0000); do_read(8'h10, 16'h0000);
    do_write(8'h11, 16'hFFFF); do_read(8'h11, 16'hFFFF);
    for (int b = 0; b < DW; b++) begin
      do_write(AW'(8'h20 + b), DW'(1) << b);
    end
    for (int b = 0; b < DW; b++) do_read(AW'(8'h20 + b), DW'(1) << b);

    // R9: fields change after acceptance.
    @(negedge clk);
    cl_req = 1; cl_wr = 1; cl_addr = 8'h05; cl_wdata = 16'hC3A5;
    @(posedge clk); @(negedge clk);
    cl_wr = 0; cl_addr = 8'h06; cl_wdata = 16'h1234;
    wait_ack(TS + TP + TH, "R9 write latency unchanged");
    cl_req = 0;
    do_read(8'h05, 16'hC3A5);
    do_read(8'h06, pat(6));
    chk(cl_rdata == pat(6), "R9 late address not written", cl_rdata, pat(6));

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule